// File: doc/BRIEF.md
# Conversion Sequencer with Automatic Sleep

This block times each conversion of a sampling converter from an active-low start strobe. It runs on the system clock and produces a busy flag, a hold flag that freezes the sample for as long as the conversion lasts, a sleep flag, and a one-cycle end-of-conversion strobe. The result word is supplied from outside, captured into an output register and handed to the serial output shifter.

No mode register exists. The level of the start input at the end of a conversion chooses the mode. If the input has already returned high, the block stays awake and waits for the next falling edge. If the input is still low, the block goes to sleep. A rising edge then starts an internally timed wake-up interval. A falling edge that arrives during wake-up is remembered, and the conversion begins as soon as wake-up ends. If the input is still high when wake-up ends, the block returns to the awake idle state, and the later falling edge starts the conversion at once. The conversion length and the wake-up length are parameters, given in clock cycles.

Top module: `conv_sequencer`

## Requirements
- R1: While reset is asserted and on release, busy, hold, asleep and eocPulse are 0 and resultOut is all zeros.
- R2: When the block is awake and idle, a falling edge on startN (sampled high, then low) raises busy and hold in the next cycle. Both stay high for exactly CONV_CYC cycles.
- R3: In the cycle in which busy and hold fall, eocPulse is 1 for that single cycle and resultOut holds the resultIn value sampled on that clock edge. Every conversion that is started produces exactly one such strobe.
- R4: If startN is 0 on the clock edge that ends a conversion, asleep becomes 1 in the same cycle as eocPulse and stays 1 until a rising edge. If startN is 1 on that edge, asleep stays 0.
- R5: While asleep, a rising edge on startN clears asleep in the next cycle and starts a wake-up of WAKE_CYC cycles. A falling edge seen during the wake-up is held pending, and busy rises WAKE_CYC+1 cycles after the cycle in which startN was first driven high.
- R6: A falling edge seen on the same clock edge on which the wake-up expires starts the conversion at once, with the same latency as R5.
- R7: If startN is still high when the wake-up expires, the block becomes awake and idle (busy 0, asleep 0). A later falling edge then starts a conversion one cycle after it, as in R2.
- R8: A falling or rising edge on startN while busy is ignored. It neither restarts nor lengthens the conversion, and it produces no second end-of-conversion strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startN | input | 1 | Active-low conversion start strobe. The falling edge samples the input; the rising edge wakes the block from sleep |
| resultIn | input | RES_W | Conversion result supplied from outside |
| busy | output | 1 | High while a conversion is in progress |
| hold | output | 1 | High while the sample is frozen |
| asleep | output | 1 | High while the block is powered down |
| eocPulse | output | 1 | One-cycle end-of-conversion strobe to the output shifter |
| resultOut | output | RES_W | Result captured at end of conversion |

## Verification
The wake-up expiry and the start request can fall on the same clock edge. The bench provokes this by driving startN low a chosen number of cycles after the wake-up rising edge: one cycle before expiry, exactly at expiry, and one cycle after. It judges each case by counting the cycles from the rising edge to the first busy sample and comparing that count with the latency the requirements give. A scoreboard queue holds one expected result for each started conversion. Each strobe is compared against that queue, which catches a strobe that is lost or one that appears twice.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } seqState_e;

  typedef struct packed {
    logic loadConv;
    logic loadWake;
    logic finish;
  } seqStrobe_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int CONV_CYC = 80,
  parameter int WAKE_CYC = 80,
  parameter int RES_W    = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startN,
  input  logic [RES_W-1:0] resultIn,
  input  seqStrobe_t       strb,
  output logic             startFall,
  output logic             startRise,
  output logic             cntZero,
  output logic [RES_W-1:0] resultOut,
  output logic             eocPulse
);
  localparam int MAX_CYC = (CONV_CYC > WAKE_CYC) ? CONV_CYC : WAKE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_CYC - 1);

  logic             prevLvl;
  logic [CNT_W-1:0] cnt;

  assign startFall = prevLvl & ~startN;
  assign startRise = ~prevLvl & startN;
  assign cntZero   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl   <= 1'b1;
      cnt       <= '0;
      resultOut <= '0;
      eocPulse  <= 1'b0;
    end else begin
      prevLvl  <= startN;
      eocPulse <= strb.finish;
      if (strb.finish) resultOut <= resultIn;
      if (strb.loadConv)      cnt <= CONV_LOAD;
      else if (strb.loadWake) cnt <= WAKE_LOAD;
      else if (!cntZero)      cnt <= cnt - 1'b1;
    end
  end

  // R3: the end strobe lasts a single cycle
  p_eoc_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    eocPulse |=> !eocPulse);
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startN,
  input  logic       startFall,
  input  logic       startRise,
  input  logic       cntZero,
  output seqStrobe_t strb,
  output logic       busy,
  output logic       hold,
  output logic       asleep
);
  seqState_e state, stateNext;
  logic      pending;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startFall) begin
        strb.loadConv = 1'b1;
        stateNext     = ST_CONV;
      end
      ST_CONV: if (cntZero) begin
        strb.finish = 1'b1;
        stateNext   = startN ? ST_IDLE : ST_SLEEP;
      end
      ST_SLEEP: if (startRise) begin
        strb.loadWake = 1'b1;
        stateNext     = ST_WAKE;
      end
      ST_WAKE: if (cntZero) begin
        if (pending || startFall) begin
          strb.loadConv = 1'b1;
          stateNext     = ST_CONV;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= (state == ST_WAKE) && !cntZero && (pending || startFall);
    end
  end

  assign busy   = (state == ST_CONV);
  assign hold   = (state == ST_CONV);
  assign asleep = (state == ST_SLEEP);

  // R4: sleep is left only through a rising edge
  p_sleep_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !startRise) |=> state == ST_SLEEP);
  // R5: a remembered start exists only during wake-up
  p_pending_scope_r5: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> state == ST_WAKE);
  // R8: an unfinished conversion is never cut short by the start input
  p_busy_ignores_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && !cntZero) |=> state == ST_CONV);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import seq_pkg::*;
#(
  parameter int CONV_CYC = 80,
  parameter int WAKE_CYC = 80,
  parameter int RES_W    = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startN,
  input  logic [RES_W-1:0] resultIn,
  output logic             busy,
  output logic             hold,
  output logic             asleep,
  output logic             eocPulse,
  output logic [RES_W-1:0] resultOut
);
  seqStrobe_t strb;
  logic startFall, startRise, cntZero;

  seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .startN(startN),
    .startFall(startFall), .startRise(startRise), .cntZero(cntZero),
    .strb(strb), .busy(busy), .hold(hold), .asleep(asleep)
  );

  seq_datapath #(.CONV_CYC(CONV_CYC), .WAKE_CYC(WAKE_CYC), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .startN(startN), .resultIn(resultIn),
    .strb(strb), .startFall(startFall), .startRise(startRise),
    .cntZero(cntZero), .resultOut(resultOut), .eocPulse(eocPulse)
  );

  // R3: the end of busy coincides with the end strobe
  p_eoc_after_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> eocPulse);
  // R4: sleep is entered only at the end of a conversion
  p_sleep_on_eoc_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> eocPulse);
endmodule

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
  localparam int C = 20;
  localparam int W = 12;
  localparam int RW = 14;

  logic clk = 1'b0;
  logic rstN, startN;
  logic [RW-1:0] resultIn;
  logic busy, hold, asleep, eocPulse;
  logic [RW-1:0] resultOut;

  int checks = 0;
  int fails = 0;
  logic [RW-1:0] expQ[$];

  always #5 clk = ~clk;

  conv_sequencer #(.CONV_CYC(C), .WAKE_CYC(W), .RES_W(RW)) dut (
    .clk(clk), .rstN(rstN), .startN(startN), .resultIn(resultIn),
    .busy(busy), .hold(hold), .asleep(asleep), .eocPulse(eocPulse),
    .resultOut(resultOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: result scoreboard and busy/hold length
  int busyRun = 0;
  bit holdBad = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (eocPulse) begin
        if (expQ.size() == 0) check(0, "R8 extra strobe", 1, 0);
        else begin
          logic [RW-1:0] e;
          e = expQ.pop_front();
          check(resultOut == e, "R3 result", resultOut, e);
        end
      end
      if (busy) begin
        busyRun++;
        if (hold !== 1'b1) holdBad = 1;
      end else if (busyRun > 0) begin
        check(busyRun == C && !holdBad && hold == 1'b0, "R2 busy/hold length", busyRun, C);
        busyRun = 0;
        holdBad = 0;
      end
    end
  end

  task automatic waitEnd(input bit expSleep, input string req);
    int n = 0;
    while (busy && n < 4 * C) begin
      @(negedge clk);
      n++;
    end
    check(eocPulse == 1'b1, "R3 strobe at busy fall", eocPulse, 1);
    check(asleep == expSleep, req, asleep, expSleep);
  endtask

  // start from awake idle; optionally toggle during busy (R8)
  task automatic normalConv(input logic [RW-1:0] v, input bit endLow, input bit glitch);
    resultIn = v;
    expQ.push_back(v);
    startN = 1'b0;
    @(negedge clk);
    check(busy == 1'b1 && hold == 1'b1, "R2 busy one cycle after fall", busy, 1);
    if (glitch) begin
      repeat (2) @(negedge clk);
      startN = 1'b1;
      repeat (2) @(negedge clk);
      startN = 1'b0;
      repeat (2) @(negedge clk);
      startN = 1'b1;
      @(negedge clk);
      startN = 1'b0;
      @(negedge clk);
    end
    if (!endLow) begin
      @(negedge clk);
      startN = 1'b1;
    end
    waitEnd(endLow, endLow ? "R4 asleep after low end" : "R4 awake after high end");
  endtask

  // from sleep: raise, then drive low at negedge number k
  task automatic wakeConv(input logic [RW-1:0] v, input int k, input string req);
    int n = 0;
    int expN;
    expN = ((k <= W) ? W : k) + 1;
    resultIn = v;
    expQ.push_back(v);
    startN = 1'b1;
    while (n < 4 * (W + k + 2)) begin
      @(negedge clk);
      n++;
      if (n == 1) check(asleep == 1'b0, "R5 asleep clears on rise", asleep, 0);
      if (busy) break;
      if (k > W + 1 && n == W + 2)
        check(!busy && !asleep, "R7 awake idle after wake", {busy, asleep}, 0);
      if (n == k) startN = 1'b0;
    end
    check(n == expN, req, n, expN);
    waitEnd(1'b1, "R4 asleep after low end");
  endtask

  initial begin
    rstN = 1'b0;
    startN = 1'b1;
    resultIn = '0;
    repeat (3) @(negedge clk);
    check(!busy && !hold && !asleep && !eocPulse && resultOut == '0, "R1 reset state",
          {busy, hold, asleep, eocPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !asleep && !eocPulse && resultOut == '0, "R1 after release",
          {busy, asleep, eocPulse}, 0);

    normalConv(14'h1A5C, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    normalConv(14'h0001, 1'b0, 1'b1);   // R8 edges during busy
    repeat (4) @(negedge clk);
    check(!busy && !eocPulse, "R8 no restart after glitch", busy, 0);

    normalConv(14'h3FFF, 1'b1, 1'b0);   // R4 ends asleep
    repeat (4) @(negedge clk);
    check(asleep == 1'b1, "R4 sleep persists", asleep, 1);

    wakeConv(14'h2AAA, 1, "R5 short pulse latency");
    repeat (3) @(negedge clk);
    wakeConv(14'h1555, W - 1, "R5 pending just before expiry");
    repeat (3) @(negedge clk);
    wakeConv(14'h0F0F, W, "R6 fall on expiry edge");
    repeat (3) @(negedge clk);
    wakeConv(14'h3003, W + 1, "R7 fall just after expiry");
    repeat (3) @(negedge clk);
    wakeConv(14'h0C3C, W + 6, "R7 long pulse latency");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 every start produced a strobe", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule